// File: doc/BRIEF.md
# Monitor Channel Byte Transmitter

This block sends a message, one byte at a time, across a frame-based control channel. In each frame it offers the current byte together with a transmit handshake bit, and it takes in one acknowledge bit from the far end. Both handshake bits are active low: 0 means active and 1 means inactive. Frame timing comes from outside as a one-cycle frame strobe. The block samples the acknowledge bit, and updates its own handshake bit, only on that strobe.

A host drives the block through a small register port. It loads a byte, sets a transmit-enable bit to open a transfer, and waits for an acknowledge interrupt. It then loads the next byte, and finally clears the enable to close the message. The host may take as long as it likes between steps. The block holds its byte and its state for any number of frames. The far end can cancel the transfer by holding its acknowledge bit inactive for two frames in a row. The block reports this through a separate abort interrupt.

Register map (2-bit address). Address 0 is the data byte, read and write. Address 1 is control: written bit 0 is transmit-enable; a read returns enable in bit 0 and channel-active in bit 1. Address 2 is interrupt enable: bit 0 for acknowledge, bit 1 for abort. Address 3 is interrupt status, with the same bit positions, and it is cleared by a read.

Top module: `mon_tx`

## Requirements
- R1: After reset, tx_mx is 1, the byte register is 0, reads of address 1 and address 3 return 0, and irq is 0.
- R2: tx_mx and the protocol state change only at clock edges where frame_stb is 1. Between strobes, and with no timeout, tx_mx holds its value for any number of frames.
- R3: While idle, if transmit-enable (address 1 bit 0) is 1 and a byte has been written to address 0, the next strobe drives tx_mx to 0 and sets channel-active (address 1 bit 1). With enable at 0, a strobe leaves tx_mx at 1.
- R4: While a byte waits for acknowledge, a strobe that samples rx_mr at 0, when the previous strobe sampled it at 1, sets status bit 0 (acknowledge) at that edge. tx_mx stays 0.
- R5: After an acknowledge, a host write to address 0 makes the next strobe drive tx_mx to 1 for exactly one frame. The strobe after that drives it back to 0.
- R6: Clearing transmit-enable after an acknowledge drives tx_mx to 1 from the next strobe on. Channel-active returns to 0 at the first strobe that samples rx_mr at 1 after tx_mx has been 1 for END_FRAMES frames.
- R7: Once the transfer has seen an acknowledge, two consecutive strobes that sample rx_mr at 1 set status bit 1 (abort) and drive tx_mx to 1. This also discards any byte written but not yet announced, and channel-active then clears as in R6.
- R8: Before the first acknowledge of a transfer, rx_mr held at 1 for any number of strobes causes no abort. A single inactive frame after an acknowledge causes no abort either.
- R9: Writes to address 0 while a byte is awaiting acknowledge are ignored. Writes at any other time replace the byte on tx_byte.
- R10: Status bits are sticky until the host reads address 3. That read returns the flags and clears them.
- R11: irq is 1 exactly when some status bit is 1 and its enable bit at address 2 is 1. A masked flag still reads back in address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per channel frame |
| rx_mr | input | 1 | Received acknowledge bit, active low |
| tx_mx | output | 1 | Transmit handshake bit, active low |
| tx_byte | output | DATA_W | Byte offered in the channel |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (clears status at address 3) |
| host_addr | input | 2 | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational from host_addr |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with DATA_W = 8 and END_FRAMES = 2. With these values the end-of-message rule and the abort recovery each finish within three frames. This lets one run cover two complete transfers: a normal close and a far-end abort. It also reaches the tied cases, such as a byte written in the same hold period that an abort arrives, and a long inactive acknowledge bit before the first acknowledge.

// File: rtl/mon_tx_pkg.sv
// Shared definitions for the monitor channel transmitter: register
// addresses, interrupt bit positions and the handshake state type.
package mon_tx_pkg;

    localparam int ADDR_W  = 2;
    localparam int IRQ_W   = 2;
    localparam int IRQ_ACK = 0;
    localparam int IRQ_ABT = 1;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer, MX inactive
        ST_WAIT,   // byte announced, waiting for acknowledge
        ST_HOLD,   // byte acknowledged, waiting for host
        ST_NEW,    // one inactive MX frame announcing a new byte
        ST_END     // MX forced inactive, closing the transfer
    } mtx_state_e;

endpackage

// File: rtl/mon_tx_mr_det.sv
// Acknowledge-bit watcher. Keeps the MR value sampled at the previous
// frame strobe and flags an active-going edge or a second inactive frame.
// Assumes rx_mr is stable around the frame strobe.
module mon_tx_mr_det (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic rx_mr,
    output logic ack_edge,
    output logic idle2
);

    logic mr_prev;

    // Keep the MR value of the previous frame (reset as inactive).
    always_ff @(posedge clk) begin
        if (!rst_n)
            mr_prev <= 1'b1;
        else if (frame_stb)
            mr_prev <= rx_mr;
    end

    // Flag inactive-to-active and inactive-twice at this frame.
    always_comb begin
        ack_edge = frame_stb && !rx_mr && mr_prev;
        idle2    = frame_stb && rx_mr && mr_prev;
    end

endmodule

// File: rtl/mon_tx_fsm.sv
// Handshake sequencer. Advances only on frame strobes. It drives MX,
// recognises acknowledge and abort, and closes a transfer after MX has
// been inactive for END_FRAMES frames and MR is inactive.
// Assumes ack_edge and idle2 are qualified by the frame strobe.
module mon_tx_fsm
    import mon_tx_pkg::*;
#(
    parameter int END_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic rx_mr,
    input  logic ack_edge,
    input  logic idle2,
    input  logic xmit_en,
    input  logic pend,
    output logic tx_mx,
    output logic active,
    output logic byte_lock,
    output logic pend_clr,
    output logic ev_ack,
    output logic ev_abort
);

    localparam int CNT_W = $clog2(END_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(END_FRAMES - 1);

    mtx_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             seen, seen_nxt;
    logic             take;

    // Next-state decision, evaluated only when a frame strobe arrives.
    always_comb begin
        nxt      = state;
        cnt_nxt  = cnt;
        ev_ack   = 1'b0;
        ev_abort = 1'b0;
        take     = 1'b0;
        if (frame_stb) begin
            case (state)
                ST_IDLE: if (xmit_en && pend) begin
                    nxt  = ST_WAIT;
                    take = 1'b1;
                end
                ST_WAIT: if (seen && idle2) begin
                    ev_abort = 1'b1;
                    nxt      = ST_END;
                end else if (ack_edge) begin
                    ev_ack = 1'b1;
                    nxt    = ST_HOLD;
                end else if (!xmit_en) begin
                    nxt = ST_END;
                end
                ST_HOLD: if (seen && idle2) begin
                    ev_abort = 1'b1;
                    nxt      = ST_END;
                end else if (!xmit_en) begin
                    nxt = ST_END;
                end else if (pend) begin
                    nxt  = ST_NEW;
                    take = 1'b1;
                end
                ST_NEW: nxt = ST_WAIT;
                ST_END: if (cnt == CNT_LAST && rx_mr) begin
                    nxt = ST_IDLE;
                end else if (cnt != CNT_LAST) begin
                    cnt_nxt = cnt + 1'b1;
                end
                default: nxt = ST_IDLE;
            endcase
            if (nxt == ST_END && state != ST_END)
                cnt_nxt = '0;
        end
    end

    // Remember that this transfer has had an acknowledge (arms abort).
    always_comb begin
        seen_nxt = seen;
        if (ev_ack)
            seen_nxt = 1'b1;
        if (nxt == ST_IDLE)
            seen_nxt = 1'b0;
    end

    // State, counter, arming flag and registered MX output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            seen  <= 1'b0;
            tx_mx <= 1'b1;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            seen  <= seen_nxt;
            tx_mx <= (nxt != ST_WAIT) && (nxt != ST_HOLD);
        end
    end

    // Status outputs toward the register block.
    always_comb begin
        active    = (state != ST_IDLE);
        byte_lock = (state == ST_WAIT) || (state == ST_NEW);
        pend_clr  = take || ev_abort;
    end

endmodule

// File: rtl/mon_tx_regs.sv
// Host register block: data byte with pending flag, transmit enable,
// interrupt enable, and sticky status that a read clears.
// Assumes event pulses last one cycle; a set wins over a same-cycle clear.
module mon_tx_regs
    import mon_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              byte_lock,
    input  logic              pend_clr,
    input  logic              ev_ack,
    input  logic              ev_abort,
    input  logic              active,
    output logic [DATA_W-1:0] tx_byte,
    output logic              xmit_en,
    output logic              pend,
    output logic [IRQ_W-1:0]  irq_stat,
    output logic              irq,
    output logic [DATA_W-1:0] host_rdata
);

    logic             data_wr;
    logic [IRQ_W-1:0] ien;
    logic [IRQ_W-1:0] ev_vec;
    logic             stat_rd;

    // Decode accepted writes and the status read.
    always_comb begin
        data_wr = host_wr && (host_addr == ADDR_DATA) && !byte_lock;
        stat_rd = host_rd && (host_addr == ADDR_STAT);
        ev_vec  = '0;
        ev_vec[IRQ_ACK] = ev_ack;
        ev_vec[IRQ_ABT] = ev_abort;
    end

    // Byte register and its pending-announcement flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
            pend    <= 1'b0;
        end else begin
            if (data_wr)
                tx_byte <= host_wdata;
            if (pend_clr)
                pend <= 1'b0;
            else if (data_wr)
                pend <= 1'b1;
        end
    end

    // Control and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xmit_en <= 1'b0;
            ien     <= '0;
        end else if (host_wr) begin
            if (host_addr == ADDR_CTRL)
                xmit_en <= host_wdata[0];
            if (host_addr == ADDR_IEN)
                ien <= host_wdata[IRQ_W-1:0];
        end
    end

    // Sticky status: events set, a status read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_stat <= '0;
        else
            irq_stat <= (stat_rd ? '0 : irq_stat) | ev_vec;
    end

    // Interrupt request and read-data mux.
    always_comb begin
        irq        = |(irq_stat & ien);
        host_rdata = '0;
        case (host_addr)
            ADDR_DATA: host_rdata = tx_byte;
            ADDR_CTRL: host_rdata[1:0] = {active, xmit_en};
            ADDR_IEN:  host_rdata[IRQ_W-1:0] = ien;
            default:   host_rdata[IRQ_W-1:0] = irq_stat;
        endcase
    end

endmodule

// File: rtl/mon_tx.sv
// Monitor channel byte transmitter top. Joins the MR watcher, the
// handshake sequencer and the host register block.
// Assumes frame_stb is a single-cycle pulse per frame.
module mon_tx
    import mon_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int END_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              rx_mr,
    output logic              tx_mx,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq
);

    logic             ack_edge, idle2;
    logic             xmit_en, pend, active, byte_lock, pend_clr;
    logic             ev_ack, ev_abort;
    logic [IRQ_W-1:0] irq_stat;

    mon_tx_mr_det u_mr (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .rx_mr     (rx_mr),
        .ack_edge  (ack_edge),
        .idle2     (idle2)
    );

    mon_tx_fsm #(.END_FRAMES(END_FRAMES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .rx_mr     (rx_mr),
        .ack_edge  (ack_edge),
        .idle2     (idle2),
        .xmit_en   (xmit_en),
        .pend      (pend),
        .tx_mx     (tx_mx),
        .active    (active),
        .byte_lock (byte_lock),
        .pend_clr  (pend_clr),
        .ev_ack    (ev_ack),
        .ev_abort  (ev_abort)
    );

    mon_tx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .byte_lock  (byte_lock),
        .pend_clr   (pend_clr),
        .ev_ack     (ev_ack),
        .ev_abort   (ev_abort),
        .active     (active),
        .tx_byte    (tx_byte),
        .xmit_en    (xmit_en),
        .pend       (pend),
        .irq_stat   (irq_stat),
        .irq        (irq),
        .host_rdata (host_rdata)
    );

endmodule

// File: rtl/mon_tx_chk.sv
// Protocol checker for mon_tx, attached with bind. It relates the frame
// strobe, the MR input and MX, the byte and the status flags over time.
module mon_tx_chk
    import mon_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_stb,
    input logic              rx_mr,
    input logic              tx_mx,
    input logic [DATA_W-1:0] tx_byte,
    input logic              host_wr,
    input logic [1:0]        host_addr,
    input logic [IRQ_W-1:0]  irq_stat,
    input logic              active
);

    AST_MX_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(tx_mx)); // R2

    AST_START_MX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> !tx_mx); // R3

    AST_ACK_ON_MR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[IRQ_ACK]) |-> $past(frame_stb) && !$past(rx_mr)); // R4

    AST_IDLE_MX_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> tx_mx); // R6

    AST_ABORT_ON_MR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[IRQ_ABT]) |-> $past(frame_stb) && $past(rx_mr) && tx_mx); // R7

    AST_BYTE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == ADDR_DATA) |=> $stable(tx_byte)); // R9

endmodule

bind mon_tx mon_tx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .rx_mr     (rx_mr),
    .tx_mx     (tx_mx),
    .tx_byte   (tx_byte),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .irq_stat  (irq_stat),
    .active    (active)
);

// File: tb/tb_mon_tx.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values tagged with the
// cycle they apply to; a monitor pops and compares late in each cycle.
module tb_mon_tx;

    localparam int CLK_PERIOD = 10;
    localparam int SEL_MX = 0, SEL_IRQ = 1, SEL_RD = 2, SEL_BYTE = 3;

    typedef struct {
        int         when;
        int         sel;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       rx_mr = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       tx_mx;
    logic [7:0] tx_byte;
    logic [7:0] host_rdata;
    logic       irq;

    item_t q[$];
    int    cyc = 0;
    int    total = 0;
    int    fails = 0;
    bit    done = 1'b0;

    mon_tx #(.DATA_W(8), .END_FRAMES(2)) dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_mr(rx_mr),
        .tx_mx(tx_mx), .tx_byte(tx_byte), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: late in each cycle, compare every item due now.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD * 3 / 4);
            while (q.size() > 0 && q[0].when <= cyc) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.sel)
                    SEL_MX:  act = {7'd0, tx_mx};
                    SEL_IRQ: act = {7'd0, irq};
                    SEL_RD:  act = host_rdata;
                    default: act = tx_byte;
                endcase
                total++;
                if (it.when != cyc || act !== it.exp) begin
                    fails++;
                    $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h",
                             it.req, it.sel, cyc, act, it.exp);
                end
            end
        end
    end

    task automatic push(int when, int sel, logic [7:0] e, string r);
        item_t it;
        it.when = when; it.sel = sel; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic drive(bit stb, bit wr, bit rd, logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        frame_stb = stb; host_wr = wr; host_rd = rd;
        host_addr = a; host_wdata = d;
    endtask

    task automatic frame(bit mr, logic [7:0] e, string r);
        drive(1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
        rx_mr = mr;
        push(cyc + 1, SEL_MX, e, r);
    endtask

    task automatic write(logic [1:0] a, logic [7:0] d);
        drive(1'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic read(logic [1:0] a, logic [7:0] e, string r);
        drive(1'b0, 1'b0, 1'b1, a, 8'd0);
        push(cyc, SEL_RD, e, r);
    endtask

    task automatic look(int sel, logic [7:0] e, string r);
        drive(1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
        push(cyc, sel, e, r);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Driver: stimulus sequence with expected values.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        look(SEL_MX, 8'd1, "R1");
        look(SEL_IRQ, 8'd0, "R1");
        read(2'd1, 8'h00, "R1");
        read(2'd3, 8'h00, "R1");
        look(SEL_BYTE, 8'h00, "R1");
        // R3 start only when enabled
        write(2'd2, 8'h03);
        write(2'd0, 8'hA5);
        frame(1'b1, 8'd1, "R3");
        write(2'd1, 8'h01);
        frame(1'b1, 8'd0, "R3");
        read(2'd1, 8'h03, "R3");
        look(SEL_BYTE, 8'hA5, "R3");
        // R8 long inactive MR before first acknowledge
        frame(1'b1, 8'd0, "R8");
        frame(1'b1, 8'd0, "R8");
        read(2'd3, 8'h00, "R8");
        // R9 write ignored while awaiting acknowledge
        write(2'd0, 8'h11);
        look(SEL_BYTE, 8'hA5, "R9");
        // R4 acknowledge, R10 sticky and read-clear
        frame(1'b0, 8'd0, "R4");
        look(SEL_IRQ, 8'd1, "R4");
        look(SEL_IRQ, 8'd1, "R10");
        read(2'd3, 8'h01, "R10");
        read(2'd3, 8'h00, "R10");
        look(SEL_IRQ, 8'd0, "R10");
        // R2 hold with no timeout
        frame(1'b0, 8'd0, "R2");
        repeat (6) drive(1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
        look(SEL_MX, 8'd0, "R2");
        frame(1'b0, 8'd0, "R2");
        // R5 new byte announced by one inactive frame
        write(2'd0, 8'h3C);
        look(SEL_BYTE, 8'h3C, "R9");
        frame(1'b0, 8'd1, "R5");
        frame(1'b0, 8'd0, "R5");
        frame(1'b1, 8'd0, "R8");
        frame(1'b0, 8'd0, "R4");
        read(2'd3, 8'h01, "R4");
        // R6 end of message
        write(2'd2, 8'h02);
        write(2'd1, 8'h00);
        frame(1'b0, 8'd1, "R6");
        read(2'd1, 8'h02, "R6");
        frame(1'b0, 8'd1, "R6");
        frame(1'b0, 8'd1, "R6");
        read(2'd1, 8'h02, "R6");
        frame(1'b1, 8'd1, "R6");
        read(2'd1, 8'h00, "R6");
        // second transfer: R11 masking, R7 abort
        write(2'd0, 8'h5A);
        write(2'd1, 8'h01);
        frame(1'b1, 8'd0, "R3");
        frame(1'b0, 8'd0, "R4");
        look(SEL_IRQ, 8'd0, "R11");
        read(2'd3, 8'h01, "R11");
        frame(1'b1, 8'd0, "R8");
        write(2'd0, 8'h77);
        look(SEL_BYTE, 8'h77, "R9");
        frame(1'b1, 8'd1, "R7");
        look(SEL_IRQ, 8'd1, "R7");
        frame(1'b1, 8'd1, "R7");
        frame(1'b1, 8'd1, "R7");
        frame(1'b1, 8'd1, "R7");
        read(2'd1, 8'h01, "R7");
        read(2'd3, 8'h02, "R7");
        drive(1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule